// File: doc/BRIEF.md
# Radix-Raising Front End for a Wide-Radix Adder

The block turns a stream of IEEE 754 double-precision words into operands for an adder that aligns in steps of a whole radix digit. The radix is `BASE`, a power of two, and the default is 64. The low `lg BASE` bits of the biased exponent are absorbed into a left shift of the significand. Only the remaining upper exponent bits go downstream, so a later alignment stage compares a narrow exponent and shifts in multiples of `BASE` bits.

The block has two register stages. The first stage unpacks the word, restores the hidden one and applies the shift. The second stage widens the result with a guard position and a sign position, then negates it when the input is negative. The valid flag and a side-band tag move in step with the data. Only normal numbers are handled. A word whose exponent field is zero is treated as zero. Infinity, NaN, denormals and rounding are not supported.

Top module: `fpbc_top`

## Requirements
- R1: `valid_o` and `tag_o` repeat `valid_i` and `tag_i` exactly two clock cycles later, with no bubbles and no reordering.
- R2: For a nonzero word (exponent field, bits 62:52, not zero), the unsigned magnitude is the 52-bit fraction (bits 51:0) with a one placed directly above it, forming a 53-bit value.
- R3: That 53-bit value is shifted left by the unsigned number held in exponent bits 52+lg BASE-1 down to 52 (bits 57:52 for BASE=64). This puts the leading one at bit position 52 plus that amount.
- R4: `exp_o` equals exponent bits 62 down to 52+lg BASE of the input word, which is 11 - lg BASE bits (5 bits, bits 62:58, for BASE=64).
- R5: When sign bit 63 is 0, `sig_o` is the shifted magnitude zero-extended to 54+BASE bits (118 for BASE=64), so its two top bits are 0.
- R6: When sign bit 63 is 1, `sig_o` is the two's-complement negation of that zero-extended magnitude.
- R7: A word whose exponent field is zero gives `sig_o` equal to 0, whatever its fraction and sign bits hold.
- R8: While `rst_ni` is low, `valid_o`, `sig_o`, `exp_o` and `tag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid |
| word_i | input | 64 | IEEE 754 double-precision word |
| tag_i | input | TAG_W | Side-band tag carried with the word |
| valid_o | output | 1 | Output operand is valid |
| sig_o | output | 54+BASE | Two's-complement significand in the wide radix |
| exp_o | output | 11-lg BASE | Upper exponent bits |
| tag_o | output | TAG_W | Tag, delayed to match the data |

## Verification
The hardest case to reach from the ports is the full range of shift amounts combined with both signs. The leading one has to land at the very top of the magnitude, where negation produces a value with many ones in the sign extension. A random stream rarely covers every one of the 64 low-exponent values in both signs. The stimulus therefore sweeps every low-exponent value deterministically. Each value is tried in both signs, with an all-ones fraction, an all-zeros fraction and a random fraction, and with the upper exponent bits and the tag varied as it goes. Zero-exponent words with nonzero fractions and idle cycles are mixed in, so the pipeline carries stale data behind a low valid flag.

// File: rtl/fpbc_pkg.sv
package fpbc_pkg;
  localparam int FP_W      = 64;
  localparam int FP_EXP_W  = 11;
  localparam int FP_FRAC_W = 52;

  typedef struct packed {
    logic                 sign;
    logic [FP_EXP_W-1:0]  exp;
    logic [FP_FRAC_W-1:0] frac;
  } fp64_t;
endpackage

// File: rtl/fpbc_unpack.sv
module fpbc_unpack
  import fpbc_pkg::*;
#(
  parameter int BASE  = 64,
  parameter int TAG_W = 8,
  localparam int LG_BASE = $clog2(BASE),
  localparam int EXP_W   = FP_EXP_W - LG_BASE,
  localparam int MAG_W   = FP_FRAC_W + BASE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [FP_W-1:0]  word_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             valid_o,
  output logic             neg_o,
  output logic [MAG_W-1:0] mag_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [TAG_W-1:0] tag_o
);
  fp64_t              fw;
  logic               is_zero;
  logic [LG_BASE-1:0] shamt;
  logic [MAG_W-1:0]   mant_ext;
  logic [MAG_W-1:0]   mag_d;

  assign fw       = fp64_t'(word_i);
  assign is_zero  = (fw.exp == '0);
  assign shamt    = fw.exp[LG_BASE-1:0];
  // hidden one is suppressed for zero exponent
  assign mant_ext = is_zero ? '0 : MAG_W'({1'b1, fw.frac});
  assign mag_d    = mant_ext << shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      neg_o   <= 1'b0;
      mag_o   <= '0;
      exp_o   <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= valid_i;
      neg_o   <= fw.sign;
      mag_o   <= mag_d;
      exp_o   <= fw.exp[FP_EXP_W-1:LG_BASE];
      tag_o   <= tag_i;
    end
  end

  AST_ZERO_MAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i[62:52] == '0) |=> (mag_o == '0)); // R7

  AST_LEAD_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i[62:52] != '0)
      |=> ((mag_o >> (int'($past(word_i[52+LG_BASE-1:52])) + 52)) == MAG_W'(1))); // R3

  AST_EXP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (exp_o == $past(word_i[62:52+LG_BASE]))); // R4
endmodule

// File: rtl/fpbc_signer.sv
module fpbc_signer #(
  parameter int BASE  = 64,
  parameter int TAG_W = 8,
  parameter int EXP_W = 5,
  localparam int MAG_W = 52 + BASE,
  localparam int SIG_W = 54 + BASE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             neg_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             valid_o,
  output logic [SIG_W-1:0] sig_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [SIG_W-1:0] ext;
  logic [SIG_W-1:0] sig_d;

  // two guard positions: carry-out and sign
  assign ext   = {2'b00, mag_i};
  assign sig_d = neg_i ? (~ext + SIG_W'(1)) : ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sig_o   <= '0;
      exp_o   <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= valid_i;
      sig_o   <= sig_d;
      exp_o   <= exp_i;
      tag_o   <= tag_i;
    end
  end

  AST_POS_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !neg_i) |=> (sig_o[SIG_W-1:SIG_W-2] == 2'b00)); // R5

  AST_NEG_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && neg_i && mag_i != '0) |=> (sig_o[SIG_W-1:SIG_W-2] == 2'b11)); // R6

  AST_NEG_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && neg_i) |=> ((sig_o + {2'b00, $past(mag_i)}) == '0)); // R6
endmodule

// File: rtl/fpbc_top.sv
module fpbc_top
  import fpbc_pkg::*;
#(
  parameter int BASE  = 64,
  parameter int TAG_W = 8,
  localparam int LG_BASE = $clog2(BASE),
  localparam int EXP_W   = FP_EXP_W - LG_BASE,
  localparam int MAG_W   = FP_FRAC_W + BASE,
  localparam int SIG_W   = 54 + BASE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [FP_W-1:0]  word_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             valid_o,
  output logic [SIG_W-1:0] sig_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [TAG_W-1:0] tag_o
);
  if ((1 << LG_BASE) != BASE || LG_BASE < 1 || LG_BASE > 10) begin : g_bad_base
    $error("BASE must be a power of two between 2 and 1024");
  end

  logic             s1_valid;
  logic             s1_neg;
  logic [MAG_W-1:0] s1_mag;
  logic [EXP_W-1:0] s1_exp;
  logic [TAG_W-1:0] s1_tag;

  fpbc_unpack #(.BASE(BASE), .TAG_W(TAG_W)) u_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .word_i  (word_i),
    .tag_i   (tag_i),
    .valid_o (s1_valid),
    .neg_o   (s1_neg),
    .mag_o   (s1_mag),
    .exp_o   (s1_exp),
    .tag_o   (s1_tag)
  );

  fpbc_signer #(.BASE(BASE), .TAG_W(TAG_W), .EXP_W(EXP_W)) u_signer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .neg_i   (s1_neg),
    .mag_i   (s1_mag),
    .exp_i   (s1_exp),
    .tag_i   (s1_tag),
    .valid_o (valid_o),
    .sig_o   (sig_o),
    .exp_o   (exp_o),
    .tag_o   (tag_o)
  );

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2)); // R1

  AST_TAG_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (tag_o == $past(tag_i, 2))); // R1
endmodule

// File: tb/fpbc_top_test.sv
module fpbc_top_test;
  localparam int BASE  = 64;
  localparam int TAG_W = 8;
  localparam int SIG_W = 54 + BASE;
  localparam int EXP_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [63:0]      word_i = '0;
  logic [TAG_W-1:0] tag_i = '0;
  logic             valid_o;
  logic [SIG_W-1:0] sig_o;
  logic [EXP_W-1:0] exp_o;
  logic [TAG_W-1:0] tag_o;

  int checks = 0;
  int fails  = 0;

  // expected entries for items driven one and two cycles ago
  logic             p_vld [2];
  logic [63:0]      p_word[2];
  logic [TAG_W-1:0] p_tag [2];

  fpbc_top #(.BASE(BASE), .TAG_W(TAG_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .word_i(word_i),
    .tag_i(tag_i), .valid_o(valid_o), .sig_o(sig_o), .exp_o(exp_o), .tag_o(tag_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [SIG_W-1:0] act,
                     input logic [SIG_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SIG_W-1:0] model(input logic [63:0] w);
    logic [SIG_W-1:0] m;
    if (w[62:52] == 11'd0) return '0;
    m = {65'd0, 1'b1, w[51:0]};
    m = m << w[57:52];
    if (w[63]) m = -m;
    return m;
  endfunction

  task automatic check_out();
    logic [SIG_W-1:0] e;
    chk(valid_o == p_vld[1], "R1 valid", SIG_W'(valid_o), SIG_W'(p_vld[1]));
    if (p_vld[1]) begin
      e = model(p_word[1]);
      chk(tag_o == p_tag[1], "R1 tag", SIG_W'(tag_o), SIG_W'(p_tag[1]));
      chk(exp_o == p_word[1][62:58], "R4 exp", SIG_W'(exp_o), SIG_W'(p_word[1][62:58]));
      if (p_word[1][62:52] == 0)
        chk(sig_o == e, "R7 zero", sig_o, e);
      else if (p_word[1][63])
        chk(sig_o == e, "R6 negative", sig_o, e);
      else begin
        chk(sig_o == e, "R2 R3 magnitude", sig_o, e);
        chk(sig_o[SIG_W-1:SIG_W-2] == 2'b00, "R5 guard", sig_o, e);
      end
    end
  endtask

  task automatic step(input logic v, input logic [63:0] w, input logic [TAG_W-1:0] t);
    @(negedge clk_i);
    check_out();
    p_vld[1] = p_vld[0]; p_word[1] = p_word[0]; p_tag[1] = p_tag[0];
    p_vld[0] = v;        p_word[0] = w;         p_tag[0] = t;
    valid_i = v; word_i = w; tag_i = t;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] tg;
    for (int i = 0; i < 2; i++) begin p_vld[i] = 0; p_word[i] = '0; p_tag[i] = '0; end
    valid_i = 1'b1; word_i = 64'hC3FF_FFFF_FFFF_FFFF; tag_i = 8'hAA;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(valid_o == 0 && sig_o == '0 && exp_o == '0 && tag_o == '0, "R8 reset",
        sig_o | SIG_W'(valid_o), '0);
    valid_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    tg = 8'd1;
    // sweep every low-exponent value, both signs, three fraction patterns
    for (int lo = 0; lo < 64; lo++) begin
      for (int s = 0; s < 2; s++) begin
        for (int f = 0; f < 3; f++) begin
          logic [51:0] fr;
          logic [4:0]  hi;
          fr = (f == 0) ? 52'd0 : (f == 1) ? '1 : {$urandom, $urandom} ;
          hi = 5'(lo * 7 + f + s);
          if (hi == 0 && lo == 0) hi = 5'd1;
          step(1'b1, {s[0], hi, lo[5:0], fr}, tg);
          tg = tg + 8'd1;
        end
        if (((lo + s) % 5) == 0) step(1'b0, {$urandom, $urandom}, 8'hFF);
      end
    end
    // zero exponent with nonzero fractions in both signs
    for (int k = 0; k < 16; k++) begin
      step(1'b1, {k[0], 11'd0, 20'(k * 977), $urandom}, 8'(k + 100));
    end
    // back-to-back random normal words
    for (int k = 0; k < 200; k++) begin
      logic [10:0] e;
      e = 11'($urandom_range(1, 2047));
      step(($urandom % 4) != 0, {1'($urandom), e, $urandom, 20'($urandom)}, 8'($urandom));
    end
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule